// File: doc/BRIEF.md
# Wired-Output Interrupt Aggregator

The block collects a parameterised set of interrupt source lines (32 by default) into a single wired interrupt line for a parent controller. Every source owns one bit position in each per-source register. A small synchronous register port gives software access to four registers:

- a cause register that holds pending events and is acknowledged by writing zeros;
- a write-only register that sets cause bits, so software can retrigger an interrupt;
- a per-source mask register;
- a control register.

One control bit selects the trigger mode for all sources at once. In level mode, a high input sets its cause bit on every clock. In rising-edge mode, only a low-to-high transition of the registered input sets its cause bit. The interrupt output is high whenever any cause bit is set while its mask bit is clear.

The register port is a single cycle. A write with `we_i` high is committed at the next rising clock edge. `rdata_o` shows the register selected by `addr_i` combinationally, in the same cycle. Byte offsets are:

| Register | Byte offset |
|---|---|
| cause | 0x00 |
| set-cause | 0x08 |
| mask | 0x10 |
| control | 0x28 |

The full address is decoded.

Top module: `irq_agg_top`

## Requirements
- R1: While reset is active and right after it, cause reads 0x00000000, mask reads 0xFFFFFFFF, control reads 0 (level mode), and `irq_o` is low.
- R2: Writing offset 0x08 sets every cause bit whose data bit is 1, visible from the next cycle. Data bits of 0 change nothing.
- R3: Writing offset 0x00 clears every cause bit whose data bit is 0 and leaves bits written 1 unchanged. Writing all zeros clears all pending bits.
- R4: `irq_o` is high exactly when some cause bit is 1 and its mask bit (offset 0x10) is 0. A mask bit of 1 blocks that source, and an all-ones mask forces `irq_o` low.
- R5: With control bit 3 set to 1 (rising-edge mode), a cause bit is set at the clock edge where its input is 1 and the input's registered previous sample is 0. An input held high does not set the bit again after it has been cleared.
- R6: With control bit 3 set to 0 (level mode), a cause bit is set at every clock edge where its input is 1, so a clear has no lasting effect until the input is low.
- R7: A hardware set event and a software clear of the same cause bit in the same cycle leave the bit set.
- R8: Control bits 3 and 5 are stored and read back as written, and all other control bits read 0. Bit 5 has no effect on `irq_o`.
- R9: Reads of offset 0x08 and of any unmapped offset return 0. Writes to unmapped offsets change no register.
- R10: A read of offset 0x00, 0x10 or 0x28 returns that register's current contents in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source lines, one per bit |
| we_i | input | 1 | Write strobe, committed at the rising edge |
| addr_i | input | AW | Byte address of the register access |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
A wrong cause bit becomes visible at the ports in two ways:
- on `rdata_o` in the first cycle the cause offset is addressed;
- on `irq_o` in the cycle after the wrong edge, whenever that bit is unmasked.

A stale edge-detect sample stays hidden until the next transition of that input. It then shows up as a missing or duplicated event one cycle later. For that reason the stimulus holds inputs high across clears in both modes, and it pairs hardware events with acknowledges in the same cycle. A mask or control register that is off by one bit shows up at once on readback. It also shows up on `irq_o` as soon as a pending bit sits in the affected position.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 6;

  localparam logic [AW-1:0] OFS_CAUSE = 6'h00;
  localparam logic [AW-1:0] OFS_SETC  = 6'h08;
  localparam logic [AW-1:0] OFS_MASK  = 6'h10;
  localparam logic [AW-1:0] OFS_CTRL  = 6'h28;

  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_MSG_BIT  = 5;

  typedef struct packed {
    logic setc;
    logic ack;
    logic mask;
    logic ctrl;
  } wr_dec_t;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         edge_mode_i,
  output logic [N-1:0] hw_set_o,
  output logic [N-1:0] src_q_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    assign hw_set_o[g] = edge_mode_i ? (src_i[g] & ~src_q[g]) : src_i[g];
  end

  assign src_q_o = src_q;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] sw_set_i,
  input  logic         ack_we_i,
  input  logic [N-1:0] ack_data_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] cause_q;
  logic [N-1:0] kept;

  // zeros in ack data clear; set events are ORed in after, so they win
  assign kept = ack_we_i ? (cause_q & ack_data_i) : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= kept | sw_set_i | hw_set_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  cause_i,
  output logic [N-1:0]  sw_set_o,
  output logic          ack_we_o,
  output logic [N-1:0]  ack_data_o,
  output logic [N-1:0]  mask_o,
  output logic          edge_mode_o,
  output logic [N-1:0]  rdata_o
);
  wr_dec_t      wr;
  logic [N-1:0] mask_q;
  logic         edge_q;
  logic         msg_q;

  assign wr.setc = we_i && (addr_i == OFS_SETC);
  assign wr.ack  = we_i && (addr_i == OFS_CAUSE);
  assign wr.mask = we_i && (addr_i == OFS_MASK);
  assign wr.ctrl = we_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      edge_q <= 1'b0;
      msg_q  <= 1'b0;
    end else begin
      if (wr.mask) mask_q <= wdata_i;
      if (wr.ctrl) begin
        edge_q <= wdata_i[CTRL_EDGE_BIT];
        msg_q  <= wdata_i[CTRL_MSG_BIT];
      end
    end
  end

  assign sw_set_o    = wr.setc ? wdata_i : '0;
  assign ack_we_o    = wr.ack;
  assign ack_data_o  = wdata_i;
  assign mask_o      = mask_q;
  assign edge_mode_o = edge_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CAUSE: rdata_o = cause_i;
      OFS_MASK:  rdata_o = mask_q;
      OFS_CTRL: begin
        rdata_o[CTRL_EDGE_BIT] = edge_q;
        rdata_o[CTRL_MSG_BIT]  = msg_q;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = irq_agg_pkg::NSRC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] sw_set;
  logic            ack_we;
  logic [NSRC-1:0] ack_data;
  logic [NSRC-1:0] cause;
  logic [NSRC-1:0] mask;
  logic            edge_mode;

  irq_src_capture #(.N(NSRC)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .edge_mode_i (edge_mode),
    .hw_set_o    (hw_set),
    .src_q_o     (src_q)
  );

  irq_cause_bank #(.N(NSRC)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_set_i   (hw_set),
    .sw_set_i   (sw_set),
    .ack_we_i   (ack_we),
    .ack_data_i (ack_data),
    .cause_o    (cause)
  );

  irq_reg_if #(.N(NSRC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cause_i     (cause),
    .sw_set_o    (sw_set),
    .ack_we_o    (ack_we),
    .ack_data_o  (ack_data),
    .mask_o      (mask),
    .edge_mode_o (edge_mode),
    .rdata_o     (rdata_o)
  );

  assign irq_o = |(cause & ~mask);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  src_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  cause_i,
  input logic [N-1:0]  mask_i,
  input logic          edge_mode_i,
  input logic [N-1:0]  src_q_i,
  input logic          irq_i
);
  p_sw_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_SETC) |=> ((cause_i & $past(wdata_i)) == $past(wdata_i)));

  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_CAUSE && src_i == '0) |=> ((cause_i & ~$past(wdata_i)) == '0));

  p_all_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_i);

  p_edge_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i |=> ((cause_i & $past(src_i & ~src_q_i)) == $past(src_i & ~src_q_i)));

  p_edge_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && !we_i && (src_i & ~src_q_i) == '0) |=> $stable(cause_i));

  // level set must survive a same-cycle clear (R7)
  p_level_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> ((cause_i & $past(src_i)) == $past(src_i)));
endmodule

bind irq_agg_top irq_agg_chk #(.N(NSRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .cause_i     (cause),
  .mask_i      (mask),
  .edge_mode_i (edge_mode),
  .src_q_i     (src_q),
  .irq_i       (irq_o)
);

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;

  logic [31:0] m_cause = '0;
  logic [31:0] m_mask  = '1;
  logic [31:0] m_ctrl  = '0;
  logic [31:0] m_prev  = '0;

  always #2.5 clk = ~clk;

  irq_agg_top dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00:   return m_cause;
      6'h10:   return m_mask;
      6'h28:   return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = '0; m_mask = '1; m_ctrl = '0; m_prev = '0;
    end else begin
      logic [31:0] hw, keep, sw;
      hw   = m_ctrl[3] ? (src & ~m_prev) : src;
      keep = (we && addr == 6'h00) ? wdata : 32'hFFFF_FFFF;
      sw   = (we && addr == 6'h08) ? wdata : 32'h0;
      m_cause = (m_cause & keep) | hw | sw;
      if (we && addr == 6'h10) m_mask = wdata;
      if (we && addr == 6'h28) m_ctrl = wdata & 32'h28;
      m_prev = src;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R4", {31'b0, irq}, {31'b0, |(m_cause & ~m_mask)});
      chk("R10", rdata, m_read(addr));
    end
  end

  task automatic op(input logic w, input logic [5:0] a, input logic [31:0] d, input logic [31:0] s);
    @(posedge clk); #1;
    we = w; addr = a; wdata = d; src = s;
  endtask

  task automatic peek(input logic [5:0] a);
    @(posedge clk); #1;
    we = 1'b0; addr = a; wdata = '0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    // R1 reset state
    addr = 6'h10; @(negedge clk); chk("R1 mask", rdata, 32'hFFFF_FFFF);
    addr = 6'h28; @(negedge clk); chk("R1 ctrl", rdata, 32'h0);
    addr = 6'h00; @(negedge clk); chk("R1 cause", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1; started = 1'b1;
    @(negedge clk); chk("R1 after reset", rdata, 32'h0);

    // level mode
    op(1'b0, 6'h00, 0, 32'h1); peek(6'h00);
    chk("R6 level set", rdata, 32'h1);
    chk("R4 masked", {31'b0, irq}, 32'h0);
    op(1'b1, 6'h10, 32'hFFFF_FFFE, 32'h1); peek(6'h10);
    chk("R4 unmask", {31'b0, irq}, 32'h1);
    op(1'b1, 6'h00, 32'hFFFF_FFFE, 32'h1); peek(6'h00);
    chk("R6 clear while high", rdata, 32'h1);
    op(1'b1, 6'h00, 32'hFFFF_FFFE, 32'h0); peek(6'h00);
    chk("R3 clear", rdata, 32'h0);
    op(1'b1, 6'h08, 32'h8000_0010, 32'h0); peek(6'h08);
    chk("R9 setc reads 0", rdata, 32'h0);
    peek(6'h00); chk("R2 set", rdata, 32'h8000_0010);
    op(1'b1, 6'h08, 32'h0, 32'h0); peek(6'h00);
    chk("R2 zeros", rdata, 32'h8000_0010);
    op(1'b1, 6'h00, 32'hFFFF_FFEF, 32'h0); peek(6'h00);
    chk("R3 ones keep", rdata, 32'h8000_0000);
    op(1'b1, 6'h10, 32'h7FFF_FFFF, 32'h0); peek(6'h10);
    chk("R4 bit31", {31'b0, irq}, 32'h1);
    op(1'b1, 6'h28, 32'h20, 32'h0); peek(6'h28);
    chk("R8 bit5", rdata, 32'h20);
    chk("R8 irq unaffected", {31'b0, irq}, 32'h1);
    op(1'b1, 6'h28, 32'hFFFF_FFFF, 32'h0); peek(6'h28);
    chk("R8 only 3,5", rdata, 32'h28);
    op(1'b1, 6'h00, 32'h0, 32'h0); peek(6'h00);
    chk("R3 clear all", rdata, 32'h0);

    // edge mode
    op(1'b0, 6'h00, 0, 32'h10); peek(6'h00);
    chk("R5 rise", rdata, 32'h10);
    op(1'b1, 6'h00, 32'h0, 32'h10); peek(6'h00);
    chk("R5 cleared", rdata, 32'h0);
    op(1'b0, 6'h00, 0, 32'h10); peek(6'h00);
    chk("R5 held high no reset", rdata, 32'h0);
    op(1'b1, 6'h00, 32'h0, 32'h12); peek(6'h00);
    chk("R7 set beats clear", rdata, 32'h2);

    // unmapped
    op(1'b1, 6'h3C, 32'hFFFF_FFFF, 32'h12); peek(6'h3C);
    chk("R9 unmapped read", rdata, 32'h0);
    peek(6'h10); chk("R9 mask untouched", rdata, 32'h7FFF_FFFF);
    peek(6'h04); chk("R9 offset 4", rdata, 32'h0);

    // back to level, open mask
    op(1'b1, 6'h28, 32'h0, 32'h0);
    op(1'b1, 6'h00, 32'h0, 32'h0); peek(6'h00);
    chk("R3 cleared in level", rdata, 32'h0);
    op(1'b1, 6'h10, 32'h0, 32'h400); peek(6'h00);
    chk("R6 bit10", rdata, 32'h400);
    chk("R4 open mask", {31'b0, irq}, 32'h1);

    // mixed traffic, checked by the reference each cycle
    lf = 32'hACE1_2345;
    for (int i = 0; i < 200; i++) begin
      logic [5:0] a;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      case (lf[2:0])
        3'd0: a = 6'h00;
        3'd1: a = 6'h08;
        3'd2: a = 6'h10;
        3'd3: a = 6'h28;
        3'd4: a = 6'h14;
        default: a = 6'h00;
      endcase
      op(lf[3] & lf[4], a, {lf[15:0], lf[31:16]}, lf & {lf[7:0], lf[31:8]});
    end
    op(1'b0, 6'h00, 0, 0);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule